// File: doc/BRIEF.md
# Dual-Clock Look-Ahead FIFO

This block carries a stream of data words from one clock domain into another whose clock bears no relation to the first. The producer pushes words with a write strobe and holds off while the full flag is high. The consumer always sees the oldest buffered word already on its data port, with a valid flag beside it, before it asks for anything. Raising the acknowledge input retires that word, and the next stored word takes its place.

Each side keeps its own fill level, counted in its own clock. These counts lag the other side by the synchroniser delay, so they describe how many words are buffered and not how many have ever been moved. Pointers cross the domain boundary in Gray code through two-stage synchronisers. The write side decides full and the read side decides valid, each from its own pointer and a delayed copy of the other pointer.

The write controller has two states. `W_ROOM` accepts writes. `W_FULL` blocks them. The transition ROOM to FULL is taken when the next fill level equals the depth. FULL to ROOM is taken once the synchronised read pointer shows free space. The read controller also has two states. `R_DRY` shows nothing. `R_SHOW` presents a stored word. The transition DRY to SHOW is taken when the synchronised write pointer differs from the next read pointer. SHOW to DRY is taken when the acknowledged word was the last one visible.

Top module: `cdc_fwft_fifo`

## Requirements
- R1: After reset, wr_full, rd_valid, wr_count and rd_count are 0 and rd_empty is 1.
- R2: While rd_valid is high and rd_ack is low, rd_data shows the oldest unread word and holds steady from one read clock to the next.
- R3: A read clock edge with rd_ack and rd_valid both high retires the shown word. Words come out in exactly the order they were accepted, none lost and none repeated.
- R4: Writing DEPTH words with no reads raises wr_full in the write cycle after the last accepted write, and wr_count then reads DEPTH.
- R5: A write attempted while wr_full is high is ignored. wr_count does not grow, and the word never appears at the read port.
- R6: An acknowledge while rd_valid is low is ignored. rd_count stays unchanged, and the next word written is still delivered.
- R7: wr_count is never below the true number of buffered words, and rd_count is never above it. Each stays within 8 words of it while traffic flows.
- R8: rd_empty is the inverse of rd_valid. When the last word is acknowledged with nothing more visible, the next read cycle shows rd_valid 0 and rd_count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No room; writes are dropped |
| wr_count | output | AW+1 | Fill level seen by the write side |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_ack | input | 1 | Retire the shown word |
| rd_data | output | DW | Oldest stored word |
| rd_valid | output | 1 | rd_data holds a real entry |
| rd_empty | output | 1 | Nothing shown |
| rd_count | output | AW+1 | Fill level seen by the read side |

## Verification
The bench fills the buffer to the brim and keeps writing. A design that checked full too late would overwrite the oldest word, and the drain would then show a foreign value out of order. It acknowledges while nothing is shown. A design that advanced the read pointer there would skip the next word, or report a wrapped count. It drains to the last word to catch a valid flag that lingers one read cycle too long and replays stale data. Under random bursts on unrelated clocks, it bounds both counts against a queue model, so that a count that runs ahead of the real fill level, or has the wrong sign, is exposed.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    typedef enum logic {
        W_ROOM = 1'b0,
        W_FULL = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_DRY  = 1'b0,
        R_SHOW = 1'b1
    } rd_state_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
    import xfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    output logic          wr_do,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic [AW:0]   count
);
    localparam int          PW    = AW + 1;
    localparam logic [AW:0] DEPTH = PW'(1 << AW);

    wr_state_e   state, state_nx;
    logic [AW:0] wbin, wbin_nx, wgray_nx, rbin_seen, fill_nx;

    // Next-state and next-pointer logic
    always_comb begin
        wr_do     = wr_en && (state == W_ROOM);
        wbin_nx   = wbin + PW'(wr_do);
        wgray_nx  = PW'(bin_to_gray(32'(wbin_nx)));
        rbin_seen = PW'(gray_to_bin(32'(rgray_sync)));
        fill_nx   = wbin_nx - rbin_seen;
        state_nx  = state;
        unique case (state)
            W_ROOM: if (fill_nx == DEPTH) state_nx = W_FULL;
            W_FULL: if (fill_nx != DEPTH) state_nx = W_ROOM;
        endcase
    end

    // State and pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= W_ROOM;
            wbin  <= '0;
            wgray <= '0;
            count <= '0;
        end else begin
            state <= state_nx;
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            count <= fill_nx;
        end
    end

    // Outputs
    always_comb begin
        full  = (state == W_FULL);
        waddr = wbin[AW-1:0];
    end
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
    import xfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic [AW:0]   wgray_sync,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          valid,
    output logic [AW:0]   count
);
    localparam int PW = AW + 1;

    rd_state_e   state, state_nx;
    logic        fire;
    logic [AW:0] rbin, rbin_nx, rgray_nx, wbin_seen, fill_nx;

    // Next-state and next-pointer logic
    always_comb begin
        fire      = ack && (state == R_SHOW);
        rbin_nx   = rbin + PW'(fire);
        rgray_nx  = PW'(bin_to_gray(32'(rbin_nx)));
        wbin_seen = PW'(gray_to_bin(32'(wgray_sync)));
        fill_nx   = wbin_seen - rbin_nx;
        state_nx  = state;
        unique case (state)
            R_DRY:  if (fill_nx != '0) state_nx = R_SHOW;
            R_SHOW: if (fill_nx == '0) state_nx = R_DRY;
        endcase
    end

    // State and pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= R_DRY;
            rbin  <= '0;
            rgray <= '0;
            count <= '0;
        end else begin
            state <= state_nx;
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            count <= fill_nx;
        end
    end

    // Outputs
    always_comb begin
        valid = (state == R_SHOW);
        raddr = rbin[AW-1:0];
    end
endmodule

// File: rtl/cdc_fwft_fifo.sv
module cdc_fwft_fifo #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    output logic [AW:0]   wr_count,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_ack,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_empty,
    output logic [AW:0]   rd_count
);
    localparam int PW = AW + 1;

    logic          wr_do;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

    xfifo_wr_ctl #(.AW(AW)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .wr_en      (wr_en),
        .rgray_sync (rgray_s),
        .wr_do      (wr_do),
        .waddr      (waddr),
        .wgray      (wgray),
        .full       (wr_full),
        .count      (wr_count)
    );

    xfifo_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    xfifo_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    xfifo_rd_ctl #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .ack        (rd_ack),
        .wgray_sync (wgray_s),
        .raddr      (raddr),
        .rgray      (rgray),
        .valid      (rd_valid),
        .count      (rd_count)
    );

    xfifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (wr_do),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_data)
    );

    assign rd_empty = ~rd_valid;
endmodule

// File: rtl/cdc_fwft_fifo_props.sv
module cdc_fwft_fifo_props #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          wr_full,
    input logic [AW:0]   wr_count,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_ack,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic [AW:0]   rd_count
);
    localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);

    // R4: full flag agrees with a count of DEPTH
    assert_full_count_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full |-> (wr_count == DEPTH));

    // R7: write-side count never exceeds the depth
    assert_count_cap_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_count <= DEPTH);

    // R5: a write into a full buffer never grows the count
    assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && wr_en) |=> (wr_count <= $past(wr_count)));

    // R2: an unacknowledged word stays shown and unchanged
    assert_hold_word_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data)));

    // R6: an acknowledge with nothing shown never lowers the count
    assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_valid && rd_ack) |=> (rd_count >= $past(rd_count)));

    // R8: a shown word implies a nonzero read-side count
    assert_valid_count_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> (rd_count != '0));
endmodule

bind cdc_fwft_fifo cdc_fwft_fifo_props #(.DW(DW), .AW(AW)) u_props (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .wr_count (wr_count),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .rd_count (rd_count)
);

// File: tb/test_cdc_fwft_fifo.sv
`timescale 1ns/100ps
module test_cdc_fwft_fifo;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int SLACK = 8;
    localparam int NRAND = 300;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_en = 0, rd_ack = 0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_valid, rd_empty;
    logic [AW:0]   wr_count, rd_count;
    logic [DW-1:0] rd_data;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DW-1:0] model[$];

    always #5    wr_clk = ~wr_clk;
    always #6.5  rd_clk = ~rd_clk;

    cdc_fwft_fifo #(.DW(DW), .AW(AW)) i_cdc_fwft_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_count(wr_count),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ack(rd_ack), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_count(rd_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 40 && !rd_valid; i++) @(negedge rd_clk);
    endtask

    task automatic t_reset_state();
        check(wr_full == 0, "R1 wr_full", wr_full, 0);
        check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        check(rd_empty == 1, "R1 rd_empty", rd_empty, 1);
        check(wr_count == 0, "R1 wr_count", wr_count, 0);
        check(rd_count == 0, "R1 rd_count", rd_count, 0);
    endtask

    task automatic t_fill_and_block();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wr_clk);
            wr_en = 1; wr_data = DW'(16'h1000 + i);
            model.push_back(wr_data);
        end
        @(negedge wr_clk);
        check(wr_full == 1, "R4 full after depth writes", wr_full, 1);
        check(wr_count == DEPTH, "R4 wr_count at full", wr_count, DEPTH);
        wr_data = 16'hDEAD;
        repeat (3) @(negedge wr_clk);
        wr_en = 0;
        check(wr_count == DEPTH, "R5 count after blocked writes", wr_count, DEPTH);
        check(wr_full == 1, "R5 still full", wr_full, 1);
        wait_valid();
        repeat (4) @(negedge rd_clk);
        check(rd_valid == 1, "R2 word shown before ack", rd_valid, 1);
        check(rd_data == model[0], "R2 oldest word shown", rd_data, model[0]);
        check(rd_count == DEPTH, "R7 rd_count at full", rd_count, DEPTH);
        repeat (3) @(negedge rd_clk);
        check(rd_data == model[0], "R2 word held without ack", rd_data, model[0]);
    endtask

    task automatic t_drain_and_idle_ack();
        for (int i = 0; i < DEPTH; i++) begin
            check(rd_valid == 1, "R3 valid during drain", rd_valid, 1);
            check(rd_data == model[0], "R3 drain order", rd_data, model[0]);
            void'(model.pop_front());
            rd_ack = 1;
            @(negedge rd_clk);
        end
        rd_ack = 0;
        check(rd_valid == 0, "R8 valid drops after last", rd_valid, 0);
        check(rd_empty == 1, "R8 empty after last", rd_empty, 1);
        check(rd_count == 0, "R8 rd_count after last", rd_count, 0);
        rd_ack = 1;
        repeat (3) @(negedge rd_clk);
        rd_ack = 0;
        check(rd_count == 0, "R6 count after idle ack", rd_count, 0);
        check(rd_valid == 0, "R6 valid after idle ack", rd_valid, 0);
        repeat (10) @(negedge wr_clk);
        check(wr_full == 0, "R7 full clears", wr_full, 0);
        check(wr_count == 0, "R7 wr_count settles", wr_count, 0);
        wr_en = 1; wr_data = 16'h0BEE;
        @(negedge wr_clk);
        wr_en = 0;
        @(negedge rd_clk);
        wait_valid();
        check(rd_valid == 1, "R6 next word delivered", rd_valid, 1);
        check(rd_data == 16'h0BEE, "R6 next word value", rd_data, 16'h0BEE);
        rd_ack = 1;
        @(negedge rd_clk);
        rd_ack = 0;
        check(rd_valid == 0, "R8 single word retired", rd_valid, 0);
    endtask

    task automatic t_random_bursts();
        int sent = 0, got = 0;
        fork
            begin
                while (sent < NRAND) begin
                    @(negedge wr_clk);
                    check(int'(wr_count) >= model.size(), "R7 wr_count not low", wr_count, model.size());
                    check(int'(wr_count) - model.size() <= SLACK, "R7 wr_count bound", wr_count, model.size());
                    wr_en = ($urandom % 3) != 0;
                    wr_data = DW'($urandom);
                    if (wr_en && !wr_full) begin
                        model.push_back(wr_data);
                        sent++;
                    end
                end
                @(negedge wr_clk);
                wr_en = 0;
            end
            begin
                while (got < NRAND) begin
                    @(negedge rd_clk);
                    check(int'(rd_count) <= model.size(), "R7 rd_count not high", rd_count, model.size());
                    check(model.size() - int'(rd_count) <= SLACK, "R7 rd_count bound", rd_count, model.size());
                    rd_ack = (($urandom % 4) != 0) && (got < NRAND);
                    if (rd_ack && rd_valid) begin
                        check(rd_data == model[0], "R3 random order", rd_data, model[0]);
                        void'(model.pop_front());
                        got++;
                    end
                end
                @(negedge rd_clk);
                rd_ack = 0;
            end
        join
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 0, "R8 empty after random traffic", rd_valid, 0);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #23 wr_rst_n = 1; rd_rst_n = 1;
        @(negedge wr_clk);
        t_reset_state();
        t_fill_and_block();
        @(negedge rd_clk);
        t_drain_and_idle_ack();
        t_random_bursts();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule